// File: doc/BRIEF.md
# SD Card Command Issue Register

This block is the command-launch register pair and response store of an SD card host. Software first writes the 32-bit command argument and then the 16-bit command word. A write to the command word with the start bit set launches the command to an external line engine, which drives the physical CMD line. The start bit then reads back as 1 until the engine reports completion. Hardware clears it at that point.

On completion the block records failure in a sticky flag when the engine reports a response timeout or a CRC7 error. A successful short response is stored in the first response word. A successful 136-bit response is stored in all four words. While a command is in flight, register writes that could disturb it are dropped. The line engine sees the stored index, argument and request flags on steady outputs, together with a one-cycle start pulse.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset every register reads 0, the start pulse is low and all engine request outputs are 0.
- R2: The argument register at offset 0x04 reads back what was written. A write to it while a command is in flight is ignored.
- R3: A write to offset 0x00 with bit 15 set while idle stores the command fields and produces a start pulse for exactly one cycle. The fields are index in bits 5:0, read-data in bit 6, write-data in bit 7, long response in bit 9, no response in bit 10 and busy-wait in bit 11. The pulse carries the stored index, argument and flags.
- R4: Command bit 15 reads 1 from launch until the cycle after the engine's done pulse, and reads 0 after that.
- R5: A write to the command register while bit 15 reads 1 is ignored. It changes neither the fields nor the engine outputs, and it produces no start pulse.
- R6: Command bit 14 is set on completion when the engine reports a timeout or a CRC error. It is cleared on completion without error, and it is cleared when a new command is launched.
- R7: On a successful completion with a short response, engine response bits 31:0 are stored at offset 0x10. Offsets 0x14, 0x18 and 0x1C keep their values.
- R8: On a successful completion with a long response, engine response bits 31:0, 63:32, 95:64 and 127:96 are stored at offsets 0x10, 0x14, 0x18 and 0x1C respectively.
- R9: On a failed completion, or when the command was issued with no response expected, all response words keep their values.
- R10: A done pulse from the engine while no command is in flight changes no register.
- R11: A write to the command register with bit 15 clear while idle updates the fields and does not launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset, used for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| eng_start_o | output | 1 | One-cycle command launch pulse |
| eng_index_o | output | 6 | Command index |
| eng_arg_o | output | 32 | Command argument |
| eng_long_o | output | 1 | 136-bit response expected |
| eng_none_o | output | 1 | No response expected |
| eng_busy_o | output | 1 | Wait for card busy to end |
| eng_rd_o | output | 1 | Read data phase follows |
| eng_wr_o | output | 1 | Write data phase follows |
| eng_done_i | input | 1 | Command completion pulse |
| eng_resp_i | input | RSP_WORDS*32 | Response bits from the engine |
| eng_timeout_i | input | 1 | Response timeout, valid with done |
| eng_crc_err_i | input | 1 | Response CRC7 error, valid with done |

## Verification
The bench sweeps 32 launches over all combinations of the five request flags, with outcomes rotating among success, timeout and CRC error. It checks each response word against a bench model. A design that captured on failure, wrote all words for a short response, or ignored the no-response flag would leave a wrong word in that model comparison. The bench also writes to the command and argument registers mid-flight, where a design without the busy guard would re-pulse start or change the engine's index. It checks that a stray done while idle leaves the fail bit alone, and that a launch after a failure clears that bit.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam logic [7:0] OFS_CMD = 8'h00;
  localparam logic [7:0] OFS_ARG = 8'h04;
  localparam logic [7:0] OFS_RSP = 8'h10;
  localparam int         WORD_W  = 32;
  localparam int         GO_BIT  = 15;

  typedef struct packed {
    logic       busy_wait;
    logic       no_rsp;
    logic       long_rsp;
    logic       wr_data;
    logic       rd_data;
    logic [5:0] index;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.index     = w[5:0];
    c.rd_data   = w[6];
    c.wr_data   = w[7];
    c.long_rsp  = w[9];
    c.no_rsp    = w[10];
    c.busy_wait = w[11];
    return c;
  endfunction
endpackage

// File: rtl/sdc_reg_decode.sv
module sdc_reg_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_wr_o,
  output logic              arg_wr_o
);
  import sdc_pkg::*;
  assign cmd_wr_o = wr_en_i && (addr_i == ADDR_W'(OFS_CMD));
  assign arg_wr_o = wr_en_i && (addr_i == ADDR_W'(OFS_ARG));
endmodule

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_wr_i,
  input  logic                 arg_wr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 eng_done_i,
  input  logic                 eng_timeout_i,
  input  logic                 eng_crc_err_i,
  output sdc_pkg::cmd_t        cmd_o,
  output logic [31:0]          arg_o,
  output logic                 run_o,
  output logic                 fail_o,
  output logic                 start_o,
  output logic                 cap_o,
  output logic                 cap_long_o
);
  import sdc_pkg::*;

  cmd_t        cmd_q;
  logic [31:0] arg_q;
  logic        run_q, fail_q, start_q;
  logic        launch, finish, bad;

  assign launch = cmd_wr_i && !run_q && wdata_i[GO_BIT];
  assign finish = run_q && eng_done_i;
  assign bad    = eng_timeout_i || eng_crc_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      arg_q   <= '0;
      run_q   <= 1'b0;
      fail_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (arg_wr_i && !run_q) arg_q <= wdata_i;
      if (cmd_wr_i && !run_q) cmd_q <= unpack_cmd(wdata_i);
      if (launch) begin
        run_q  <= 1'b1;
        fail_q <= 1'b0;
      end else if (finish) begin
        run_q  <= 1'b0;
        fail_q <= bad;
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign arg_o      = arg_q;
  assign run_o      = run_q;
  assign fail_o     = fail_q;
  assign start_o    = start_q;
  assign cap_o      = finish && !bad && !cmd_q.no_rsp;
  assign cap_long_o = cmd_q.long_rsp;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  // R4
  run_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(eng_done_i));
  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(cmd_q) && $stable(arg_q));
  // R6
  fail_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> !fail_q && run_q);
  // R10
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && eng_done_i && !cmd_wr_i) |=> $stable(fail_q) && !run_q);
endmodule

// File: rtl/sdc_resp_store.sv
module sdc_resp_store #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cap_i,
  input  logic                          long_i,
  input  logic [NWORDS*WORD_W-1:0]      resp_i,
  output logic [NWORDS-1:0][WORD_W-1:0] words_o
);
  logic [NWORDS-1:0][WORD_W-1:0] words_q;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic load;
    if (i == 0) begin : g_first
      assign load = cap_i;
    end else begin : g_rest
      assign load = cap_i && long_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   words_q[i] <= '0;
      else if (load) words_q[i] <= resp_i[i*WORD_W +: WORD_W];
    end
  end

  assign words_o = words_q;

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(words_q));
  // R7
  short_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !long_i) |=> $stable(words_q[NWORDS-1]));
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue #(
  parameter int ADDR_W    = 8,
  parameter int RSP_WORDS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    eng_start_o,
  output logic [5:0]              eng_index_o,
  output logic [31:0]             eng_arg_o,
  output logic                    eng_long_o,
  output logic                    eng_none_o,
  output logic                    eng_busy_o,
  output logic                    eng_rd_o,
  output logic                    eng_wr_o,
  input  logic                    eng_done_i,
  input  logic [RSP_WORDS*32-1:0] eng_resp_i,
  input  logic                    eng_timeout_i,
  input  logic                    eng_crc_err_i
);
  import sdc_pkg::*;
  localparam int RSP_W = RSP_WORDS * WORD_W;

  logic cmd_wr, arg_wr, run, fail, cap, cap_long;
  cmd_t cmd;
  logic [31:0] arg;
  logic [RSP_WORDS-1:0][WORD_W-1:0] words;

  sdc_reg_decode #(.ADDR_W(ADDR_W)) i_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .cmd_wr_o(cmd_wr),
    .arg_wr_o(arg_wr)
  );

  sdc_cmd_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr),
    .arg_wr_i     (arg_wr),
    .wdata_i      (wdata_i),
    .eng_done_i   (eng_done_i),
    .eng_timeout_i(eng_timeout_i),
    .eng_crc_err_i(eng_crc_err_i),
    .cmd_o        (cmd),
    .arg_o        (arg),
    .run_o        (run),
    .fail_o       (fail),
    .start_o      (eng_start_o),
    .cap_o        (cap),
    .cap_long_o   (cap_long)
  );

  sdc_resp_store #(.NWORDS(RSP_WORDS), .WORD_W(WORD_W)) i_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .long_i (cap_long),
    .resp_i (eng_resp_i[RSP_W-1:0]),
    .words_o(words)
  );

  assign eng_index_o = cmd.index;
  assign eng_arg_o   = arg;
  assign eng_long_o  = cmd.long_rsp;
  assign eng_none_o  = cmd.no_rsp;
  assign eng_busy_o  = cmd.busy_wait;
  assign eng_rd_o    = cmd.rd_data;
  assign eng_wr_o    = cmd.wr_data;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CMD))
      rdata_o = {16'h0, run, fail, 2'b00, cmd.busy_wait, cmd.no_rsp,
                 cmd.long_rsp, 1'b0, cmd.wr_data, cmd.rd_data, cmd.index};
    else if (addr_i == ADDR_W'(OFS_ARG))
      rdata_o = arg;
    for (int i = 0; i < RSP_WORDS; i++)
      if (addr_i == ADDR_W'(32'(OFS_RSP) + 32'(4 * i))) rdata_o = words[i];
  end

  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> $past(!run && cmd_wr && wdata_i[GO_BIT]));
endmodule

// File: tb/test_sd_cmd_issue.sv
module test_sd_cmd_issue;
  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic st, e_long, e_none, e_busy, e_rd, e_wr;
  logic [5:0] e_idx;
  logic [31:0] e_arg;
  logic done = 0, to = 0, crc = 0;
  logic [127:0] resp = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_rsp [4];

  always #10 clk = ~clk;

  sd_cmd_issue i_sd_cmd_issue (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .eng_start_o(st), .eng_index_o(e_idx),
    .eng_arg_o(e_arg), .eng_long_o(e_long), .eng_none_o(e_none),
    .eng_busy_o(e_busy), .eng_rd_o(e_rd), .eng_wr_o(e_wr),
    .eng_done_i(done), .eng_resp_i(resp), .eng_timeout_i(to),
    .eng_crc_err_i(crc));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic finish_cmd(input logic t, input logic c, input logic [127:0] r);
    @(negedge clk); done = 1; to = t; crc = c; resp = r;
    @(negedge clk); done = 0; to = 0; crc = 0;
  endtask

  task automatic check_rsp(input string req);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(8'h10 + 8'(4 * i), v);
      check(req, 64'(v), 64'(exp_rsp[i]));
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    logic [127:0] r;
    for (int i = 0; i < 4; i++) exp_rsp[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v); check("R1 cmd", 64'(v), 0);
    rd(8'h04, v); check("R1 arg", 64'(v), 0);
    check("R1 engine", 64'({st, e_idx, e_arg, e_long, e_none, e_busy, e_rd, e_wr}), 0);
    check_rsp("R1 rsp");

    // R2 argument readback
    wr(8'h04, 32'hCAFE_0123);
    rd(8'h04, v); check("R2 arg", 64'(v), 64'h0000_0000_CAFE_0123);

    // R11 field write without launch
    wr(8'h00, 32'h0000_0E45);
    check("R11 no start", 64'(st), 0);
    rd(8'h00, v); check("R11 fields", 64'(v), 64'h0E45);

    // sweep all flag combinations and outcomes
    for (int k = 0; k < 32; k++) begin
      logic [5:0] idx;
      logic rdf, wrf, lg, nn, bw;
      int err;
      idx = 6'((k * 7 + 3) % 64);
      {bw, nn, lg, wrf, rdf} = 5'(k);
      err = k % 3;
      c = 32'(idx) | (32'(rdf) << 6) | (32'(wrf) << 7) | (32'(lg) << 9)
        | (32'(nn) << 10) | (32'(bw) << 11);
      wr(8'h04, 32'h5A00_0000 + 32'(k));
      wr(8'h00, c | 32'h8000);
      // R3 one-cycle start with stored fields
      check("R3 start", 64'({st, e_idx, e_arg, e_long, e_none, e_busy, e_rd, e_wr}),
            64'({1'b1, idx, 32'h5A00_0000 + 32'(k), lg, nn, bw, rdf, wrf}));
      rd(8'h00, v);
      // R4 busy readback, R6 fail cleared on launch
      check("R4 busy", 64'(v), 64'(c | 32'h8000));
      @(negedge clk);
      check("R3 pulse width", 64'(st), 0);
      for (int i = 0; i < 4; i++)
        r[i*32 +: 32] = 32'h1000_0000 * (i + 1) + 32'(k) * 32'h0101 + 32'(i);
      finish_cmd(err == 1, err == 2, r);
      rd(8'h00, v);
      check("R4/R6 after done", 64'(v), 64'(c | (err != 0 ? 32'h4000 : 0)));
      if (err == 0 && !nn) begin
        exp_rsp[0] = r[31:0];
        if (lg) for (int i = 1; i < 4; i++) exp_rsp[i] = r[i*32 +: 32];
      end
      check_rsp(lg ? "R8/R9 rsp" : "R7/R9 rsp");
    end

    // R5 / R2 writes while in flight
    wr(8'h04, 32'h1111_2222);
    wr(8'h00, 32'h8000 | 32'd17);
    wr(8'h00, 32'h8000 | 32'h0200 | 32'd40);
    check("R5 no restart", 64'(st), 0);
    check("R5 engine index", 64'(e_idx), 17);
    wr(8'h00, 32'h0000_0640);
    wr(8'h04, 32'h3333_4444);
    rd(8'h00, v); check("R5 fields", 64'(v), 64'h8011);
    rd(8'h04, v); check("R2 arg held", 64'(v), 64'h1111_2222);
    finish_cmd(1, 0, '1);
    rd(8'h00, v); check("R6 fail set", 64'(v), 64'h4011);
    check_rsp("R9 fail keep");

    // R10 done while idle
    finish_cmd(0, 0, {4{32'hDEAD_BEEF}});
    rd(8'h00, v); check("R10 cmd", 64'(v), 64'h4011);
    check_rsp("R10 rsp");

    // R6 launch clears fail
    wr(8'h00, 32'h8000 | 32'd2);
    rd(8'h00, v); check("R6 cleared", 64'(v), 64'h8002);
    finish_cmd(0, 0, 128'h0);
    exp_rsp[0] = 0;
    check_rsp("R7 zero rsp");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule